// File: doc/BRIEF.md
# Flat-ROM Microcode Sequencer

This block is the control unit of a microprogrammed processor. It holds one flat microcode store and a 10-bit address register. Every cycle it reads exactly one microword and drives it out as the control word. There is no separate opcode-dispatch lookup and no separate condition-target lookup.

The address of the next microword is put together from three parts. The low five bits are the current microword's next-state field. Above them sits one condition bit: the zero-flag register gated by the microword's test bit. The top four bits are the opcode gated by the microword's dispatch bit.

The zero-flag register is loaded from the datapath's comparator output only in cycles whose microword asks for it. Because gated address bits can land the sequence in any bank, the fetch words are repeated in every bank of the store. The user connects the opcode field and the comparator output. The control word then steers the datapath.

Top module: `flat_useq`

## Requirements
- R1: A synchronous active-high reset returns the address to 0. While reset holds, and in the cycle after it is released, the control word is the first fetch word, 16'h0101.
- R2: The control word is laid out as follows: bits [4:0] are the next-state field, bit 5 is the test bit, bit 6 is the dispatch bit, bit 7 is the zero-load bit, and bits [15:8] are the action strobes. At each clock, address bits [4:0] take the next-state field of the current word.
- R3: At each clock, address bit 5 takes the AND of the current word's test bit and the zero-flag register. When the test bit is 0, address bit 5 becomes 0 whatever the flag holds.
- R4: At each clock, address bits [9:6] take the AND of the current word's dispatch bit and the 4-bit opcode input. When the dispatch bit is 0, they become 0 and the opcode is ignored.
- R5: The zero-flag register loads the comparator input at a clock only when the current word's zero-load bit is 1. Otherwise it holds, and the comparator input has no effect. Reset clears the register to 0.
- R6: The fetch words at state 0, 1 and 2 are the same in all 32 banks (opcode and flag bits). State 0 holds strobes 8'h01 with next state 1. State 1 holds strobes 8'h02 with next state 2. State 2 holds strobes 8'h04 with next state 3 and the dispatch bit set.
- R7: The execute words of the store, for opcode o and flag bank z, are as follows. State 3 holds strobes {o,4'h8}, next state 4, the dispatch bit and the zero-load bit. State 4 holds strobes {o,4'h9}, next state 5, and the dispatch and test bits. State 5 holds strobes {o,3'b101,z} and next state 0, with the dispatch and test bits both equal to o[3]. All other states hold strobes 8'hEE and next state 0, with no flag bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field of the current instruction |
| zeroIn | input | 1 | Comparator zero result from the datapath |
| ctrlWord | output | 16 | Current microword driven as the control word |

## Verification
The hardest case to reach from the ports is a gated address that lands in a non-zero bank at state 0. That happens only when an instruction with opcode bit 3 set ends its state-5 word with both gates open, so the next fetch is read from a cloned copy. The bench sweeps every opcode against both flag values. It drives the inverted opcode and the inverted comparator input in every cycle where they should be ignored. The effect of the flag gate therefore shows only through the flag bit in the state-5 strobes, and the clone is read at the start of the next instruction.

// File: rtl/flat_useq_pkg.sv
package flat_useq_pkg;
  localparam int OP_W   = 4;
  localparam int ST_W   = 5;
  localparam int ACT_W  = 8;
  localparam int ADDR_W = OP_W + 1 + ST_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int Z_POS  = ST_W;
  localparam int OP_LSB = ST_W + 1;

  // Microword: strobes on top, sequencing fields at the bottom.
  typedef struct packed {
    logic [ACT_W-1:0] act;
    logic             loadZ;
    logic             mBit;
    logic             tBit;
    logic [ST_W-1:0]  nxt;
  } uword_t;

  localparam int WORD_W = $bits(uword_t);

  // Sequencing strobes passed from control to datapath.
  typedef struct packed {
    logic [ST_W-1:0] nxt;
    logic            tBit;
    logic            mBit;
    logic            loadZ;
  } seqStrobes_t;

  // Microprogram generator: fetch is the same in every bank.
  function automatic uword_t romWord(input logic [ADDR_W-1:0] a);
    uword_t          w;
    logic [ST_W-1:0] s;
    logic            z;
    logic [OP_W-1:0] op;
    s  = a[ST_W-1:0];
    z  = a[Z_POS];
    op = a[ADDR_W-1:OP_LSB];
    w  = '0;
    case (s)
      ST_W'(0): begin w.act = 8'h01; w.nxt = ST_W'(1); end
      ST_W'(1): begin w.act = 8'h02; w.nxt = ST_W'(2); end
      ST_W'(2): begin w.act = 8'h04; w.nxt = ST_W'(3); w.mBit = 1'b1; end
      ST_W'(3): begin
        w.act = {op, 4'h8}; w.nxt = ST_W'(4); w.mBit = 1'b1; w.loadZ = 1'b1;
      end
      ST_W'(4): begin
        w.act = {op, 4'h9}; w.nxt = ST_W'(5); w.mBit = 1'b1; w.tBit = 1'b1;
      end
      ST_W'(5): begin
        w.act = {op, 3'b101, z}; w.nxt = '0;
        w.mBit = op[OP_W-1]; w.tBit = op[OP_W-1];
      end
      default: begin w.act = 8'hEE; w.nxt = '0; end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/flat_useq_ctl.sv
module flat_useq_ctl
  import flat_useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output seqStrobes_t       seq,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] romMem [DEPTH];
  uword_t            cur;

  // Constant store filled from the generator, one entry per address.
  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign romMem[i] = romWord(ADDR_W'(i));
  end

  always_comb begin
    cur       = uword_t'(romMem[addr]);
    word      = romMem[addr];
    seq.nxt   = cur.nxt;
    seq.tBit  = cur.tBit;
    seq.mBit  = cur.mBit;
    seq.loadZ = cur.loadZ;
  end

  // R6: any state-0 address yields the same fetch word
  a_r6_fetch_clone: assert property (@(posedge clk) disable iff (rst)
    (addr[ST_W-1:0] == '0) |-> (word == WORD_W'(16'h0101)));

  // R7: state 5 returns to state 0 in the next-state field
  a_r7_state5_returns: assert property (@(posedge clk) disable iff (rst)
    (addr[ST_W-1:0] == ST_W'(5)) |-> (seq.nxt == '0));
endmodule

// File: rtl/flat_useq_path.sv
module flat_useq_path
  import flat_useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              zeroIn,
  input  seqStrobes_t       seq,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrD;
  logic              zReg;

  always_comb begin
    addrD[ST_W-1:0]          = seq.nxt;
    addrD[Z_POS]             = seq.tBit & zReg;
    addrD[ADDR_W-1:OP_LSB]   = opcode & {OP_W{seq.mBit}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      zReg  <= 1'b0;
    end else begin
      addrQ <= addrD;
      if (seq.loadZ) zReg <= zeroIn;
    end
  end

  assign addr = addrQ;

  // R1: reset lands at the fetch start
  a_r1_reset_home: assert property (@(posedge clk)
    $past(rst) |-> (addrQ == '0));

  // R2: low bits follow the previous next-state field
  a_r2_next_field: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (addrQ[ST_W-1:0] == $past(seq.nxt)));

  // R3: closed test gate gives a zero condition bit
  a_r3_test_gate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(seq.tBit)) |-> !addrQ[Z_POS]);

  // R4: closed dispatch gate gives a zero opcode bank
  a_r4_dispatch_gate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(seq.mBit)) |-> (addrQ[ADDR_W-1:OP_LSB] == '0));

  // R5: flag register holds without a load strobe
  a_r5_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(seq.loadZ)) |-> $stable(zReg));
endmodule

// File: rtl/flat_useq.sv
module flat_useq
  import flat_useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              zeroIn,
  output logic [WORD_W-1:0] ctrlWord
);
  seqStrobes_t       seq;
  logic [ADDR_W-1:0] addr;

  flat_useq_ctl u_ctl (
    .clk  (clk),
    .rst  (rst),
    .addr (addr),
    .seq  (seq),
    .word (ctrlWord)
  );

  flat_useq_path u_path (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .zeroIn (zeroIn),
    .seq    (seq),
    .addr   (addr)
  );
endmodule

// File: tb/flat_useq_bench.sv
`timescale 1ns/1ps
module flat_useq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'h0;
  logic        zeroIn = 1'b0;
  logic [15:0] ctrlWord;

  int nChk = 0;
  int nBad = 0;
  logic [9:0] mAddr = '0;
  logic       mZ = 1'b0;

  always #2.5 clk = ~clk;

  flat_useq u_flat_useq (
    .clk(clk), .rst(rst), .opcode(opcode), .zeroIn(zeroIn), .ctrlWord(ctrlWord)
  );

  // Expected microword from the requirement text (R6, R7 layout per R2).
  function automatic logic [15:0] expWord(input logic [9:0] a);
    logic [4:0] s; logic z; logic [3:0] o;
    logic [7:0] act; logic lz, m, t; logic [4:0] n;
    s = a[4:0]; z = a[5]; o = a[9:6];
    lz = 0; m = 0; t = 0;
    if (s == 0)      begin act = 8'h01; n = 5'd1; end
    else if (s == 1) begin act = 8'h02; n = 5'd2; end
    else if (s == 2) begin act = 8'h04; n = 5'd3; m = 1; end
    else if (s == 3) begin act = {o, 4'h8}; n = 5'd4; m = 1; lz = 1; end
    else if (s == 4) begin act = {o, 4'h9}; n = 5'd5; m = 1; t = 1; end
    else if (s == 5) begin act = {o, 3'b101, z}; n = 5'd0; m = o[3]; t = o[3]; end
    else             begin act = 8'hEE; n = 5'd0; end
    return {act, lz, m, t, n};
  endfunction

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: ctrlWord=%h expected=%h (model addr=%h)", tag, got, exp, mAddr);
    end
  endtask

  // One cycle: drive at negedge, check the current word, advance the model.
  task automatic step(input logic [3:0] op, input logic zin, input string tag);
    logic [15:0] w;
    opcode = op; zeroIn = zin;
    #1;
    w = expWord(mAddr);
    check(ctrlWord, w, tag);
    @(posedge clk);
    @(negedge clk);
    mAddr = {(w[6] ? op : 4'h0), (w[5] & mZ), w[4:0]};
    if (w[7]) mZ = zin;
  endtask

  task automatic doReset(input string tag);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(ctrlWord, 16'h0101, tag);
    rst = 1'b0;
    mAddr = '0; mZ = 1'b0;
    #1;
    check(ctrlWord, 16'h0101, tag);
  endtask

  // One instruction; ignored inputs carry inverted noise.
  task automatic runInstr(input logic [3:0] op, input logic z);
    step(~op, ~z, "R6 fetch0");
    step(~op, ~z, "R4 fetch1 opcode ignored");
    step(op,  ~z, "R2 dispatch word");
    step(op,  z,  "R7 execute load flag");
    step(op,  ~z, "R5 flag test word");
    step(op[3] ? op : ~op, ~z, "R3 flag bit in strobes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    doReset("R1");
    for (int pass = 0; pass < 2; pass++)
      for (int o = 0; o < 16; o++)
        for (int z = 0; z < 2; z++)
          runInstr(4'(o), 1'(z));
    // Reset in mid-instruction.
    step(4'h5, 1'b0, "R6 fetch0");
    step(4'h5, 1'b0, "R4 fetch1");
    step(4'h5, 1'b1, "R2 dispatch");
    doReset("R1 mid-run");
    runInstr(4'hC, 1'b1);
    runInstr(4'h3, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: run did not finish, got=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule